// File: doc/BRIEF.md
# Parallel PRBS and Comma Test-Pattern Source

This block feeds a high-speed serial transmitter with ten-bit test words, one per cycle of the word-rate clock. The line rate is therefore ten times the word rate. Two sources run side by side.

The first source is a ten-stage pseudo-random generator built on the polynomial x^10 + x^7 + 1. Its feedback is unrolled ten steps within one clock, so each cycle it produces the next ten bits of a maximal-length bit stream with period 1023. The second source alternates the two running-disparity forms of the K28.5 comma character. That pair of words holds the longest runs the code allows (five equal bits) and the shortest isolated pulses, which makes it useful for checking eye and jitter.

A pattern select drives ten per-bit two-input selectors and picks the source. The chosen word is registered together with a valid flag. A one-cycle restart pulse returns both sources to a known starting point. A synchronous reset does the same.

Top module: `tpat_source`

## Requirements
- R1: While reset or restart is high at a clock edge, the word registered at that edge is all zeros and `word_vld` is low. At every edge where both are low, `word_vld` is high.
- R2: The first pseudo-random word after a restart comes from the all-ones seed and equals 10'h3FF.
- R3: Bit 0 of each word is the first bit on the line. Consecutive pseudo-random words are consecutive ten-bit slices of the serial stream s(n) = s(n-7) xor s(n-10), and each bit equals the oldest stage of the ten-bit state.
- R4: The pseudo-random word stream repeats with period 1023 words. Over one period the 10230 bits contain exactly 5120 ones.
- R5: No pseudo-random word is all zeros.
- R6: The comma source emits 10'h283 (line order 1100000101, negative disparity) first after reset or restart. It then alternates with 10'h17C (line order 0011111010, positive disparity).
- R7: Both sources advance on every non-restart cycle, whichever one is selected. `sel_comma` high selects the comma source and low selects the pseudo-random source.
- R8: A restart in the middle of a stream reseeds the pseudo-random source and returns the comma source to its negative-disparity word.
- R9: `sel_comma` is sampled only at the edge that registers a word. Every output word is taken whole from one source, including when the select toggles every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | One-cycle synchronous pattern restart |
| sel_comma | input | 1 | 1 selects the comma source, 0 the pseudo-random source |
| word_out | output | 10 | Registered test word, bit 0 sent first |
| word_vld | output | 1 | High when `word_out` carries a generated word |

## Verification
The hardest property to reach from the ports is the full period: it shows only after 1023 consecutive pseudo-random words. The stimulus therefore runs a sweep longer than one period without interruption. The bench compares every word against a bit-serial model and counts the ones over exactly one period.

A second hard case is a source advancing while it is not selected. It is reached by toggling the select every cycle, and with other select patterns, and then checking that each source resumes where its free-running model says it should.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    localparam int LFSR_LEN = 10;
    localparam int WORD_W   = 10;
    localparam int TAP_HI   = LFSR_LEN - 1;
    localparam int TAP_LO   = 6;

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [LFSR_LEN-1:0] lfsr_t;

    localparam word_t COMMA_NEG = 10'h283;
    localparam word_t COMMA_POS = 10'h17C;
    localparam lfsr_t SEED_ONES = '1;

    typedef enum logic {
        PH_NEG = 1'b0,
        PH_POS = 1'b1
    } disp_e;

    typedef struct packed {
        word_t prbs;
        word_t comma;
    } src_pair_t;

    function automatic lfsr_t lfsr_step(lfsr_t s);
        return {s[LFSR_LEN-2:0], s[TAP_HI] ^ s[TAP_LO]};
    endfunction

    function automatic word_t comma_for(disp_e ph);
        return (ph == PH_NEG) ? COMMA_NEG : COMMA_POS;
    endfunction

endpackage

// File: rtl/tpat_prbs_src.sv
module tpat_prbs_src
    import tpat_pkg::*;
#(
    parameter lfsr_t SEED = SEED_ONES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    output word_t word
);
    localparam int STAGES = WORD_W + 1;

    lfsr_t state_q;
    lfsr_t chain [STAGES];

    assign chain[0] = state_q;

    generate
        for (genvar k = 0; k < WORD_W; k++) begin : g_unroll
            assign word[k]      = chain[k][TAP_HI];
            assign chain[k + 1] = lfsr_step(chain[k]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= SEED;
        end else begin
            state_q <= chain[WORD_W];
        end
    end

endmodule

// File: rtl/tpat_comma_src.sv
module tpat_comma_src
    import tpat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    output word_t word
);
    disp_e phase_q;

    assign word = comma_for(phase_q);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= PH_NEG;
        end else begin
            phase_q <= (phase_q == PH_NEG) ? PH_POS : PH_NEG;
        end
    end

endmodule

// File: rtl/tpat_bit_mux.sv
module tpat_bit_mux
    import tpat_pkg::*;
(
    input  src_pair_t src,
    input  logic      sel_comma,
    output word_t     y
);
    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            assign y[b] = sel_comma ? src.comma[b] : src.prbs[b];
        end
    endgenerate

endmodule

// File: rtl/tpat_source.sv
module tpat_source
    import tpat_pkg::*;
#(
    parameter lfsr_t SEED = SEED_ONES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              sel_comma,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);
    src_pair_t srcs;
    word_t     picked;

    tpat_prbs_src #(.SEED(SEED)) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .word    (srcs.prbs)
    );

    tpat_comma_src u_comma (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .word    (srcs.comma)
    );

    tpat_bit_mux u_mux (
        .src       (srcs),
        .sel_comma (sel_comma),
        .y         (picked)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_out <= picked;
            word_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/tpat_source_chk.sv
module tpat_source_chk
    import tpat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              restart,
    input logic              sel_comma,
    input logic [WORD_W-1:0] word_out,
    input logic              word_vld
);
    AST_RESTART_BLANKS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!word_vld && word_out == '0)); // R1

    AST_RUN_VALID: assert property (@(posedge clk) disable iff (rst)
        !restart |=> word_vld); // R1

    AST_SEED_WORD: assert property (@(posedge clk) disable iff (rst)
        restart ##1 (!restart && !sel_comma) |=> word_out == 10'h3FF); // R2

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (!restart && !sel_comma) |=> word_out != '0); // R5

    AST_COMMA_FIRST_NEG: assert property (@(posedge clk) disable iff (rst)
        restart ##1 (!restart && sel_comma) |=> word_out == COMMA_NEG); // R6

    AST_COMMA_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (word_vld && $past(sel_comma) && word_out == COMMA_NEG && sel_comma && !restart)
        |=> word_out == COMMA_POS); // R6

endmodule

bind tpat_source tpat_source_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .sel_comma (sel_comma),
    .word_out  (word_out),
    .word_vld  (word_vld)
);

// File: tb/tpat_source_test.sv
`timescale 1ns/1ps
module tpat_source_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restart = 1'b0;
    logic       sel_comma = 1'b0;
    logic [9:0] word_out;
    logic       word_vld;

    always #2.5 clk = ~clk;

    tpat_source uut (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .sel_comma (sel_comma),
        .word_out  (word_out),
        .word_vld  (word_vld)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [9:0] m_state;
    logic       m_pos;
    logic [9:0] exp_w;
    logic       exp_v;
    logic [9:0] last_prbs;

    // Bit-serial reference: one line bit per step, oldest stage first.
    function automatic logic [9:0] ref_slice(ref logic [9:0] st);
        logic [9:0] w;
        for (int i = 0; i < 10; i++) begin
            w[i] = st[9];
            st   = {st[8:0], st[9] ^ st[6]};
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic model(input logic r, input logic s);
        logic [9:0] pw;
        logic [9:0] cw;
        if (r) begin
            m_state = 10'h3FF;
            m_pos   = 1'b0;
            exp_w   = '0;
            exp_v   = 1'b0;
        end else begin
            pw        = ref_slice(m_state);
            last_prbs = pw;
            cw        = m_pos ? 10'h17C : 10'h283;
            m_pos     = ~m_pos;
            exp_w     = s ? cw : pw;
            exp_v     = 1'b1;
        end
    endtask

    task automatic step(input logic r, input logic s, input string tag);
        restart   = r;
        sel_comma = s;
        @(posedge clk);
        #1;
        model(r, s);
        check(tag, word_out, exp_w);
        check({tag, " valid"}, {9'd0, word_vld}, {9'd0, exp_v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] first_w;
        int         ones;
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        model(1'b1, 1'b0);
        check("R1 reset word", word_out, 10'h000);
        check("R1 reset valid", {9'd0, word_vld}, 10'h000);
        rst = 1'b0;

        // R2..R5: full period of the pseudo-random stream
        step(1'b1, 1'b0, "R1 restart");
        ones = 0;
        for (int n = 0; n < 1030; n++) begin
            step(1'b0, 1'b0, "R3 prbs stream");
            if (n == 0) begin
                first_w = word_out;
                check("R2 seed word", word_out, 10'h3FF);
            end
            if (n < 1023) ones += $countones(word_out);
            if (n == 1023) check("R4 period repeat", word_out, first_w);
            if (word_out == 10'h000) check("R5 nonzero", word_out, 10'h001);
        end
        check("R4 ones per period", ones[9:0], 10'(5120 & 10'h3FF));
        checks++;
        if (ones != 5120) begin
            fails++;
            $display("FAIL R4 ones: got %0d expected 5120", ones);
        end

        // R6: comma alternation from negative disparity
        step(1'b1, 1'b1, "R1 restart");
        step(1'b0, 1'b1, "R6 comma");
        check("R6 first neg", word_out, 10'h283);
        step(1'b0, 1'b1, "R6 comma");
        check("R6 then pos", word_out, 10'h17C);
        for (int n = 0; n < 6; n++) step(1'b0, 1'b1, "R6 comma");

        // R7 / R9: select toggling, sources keep advancing
        for (int n = 0; n < 40; n++) step(1'b0, n[0], "R9 toggle");
        for (int n = 0; n < 60; n++) step(1'b0, n[2] ^ n[4], "R7 mixed select");
        for (int n = 0; n < 5; n++) step(1'b0, 1'b1, "R7 comma run");
        step(1'b0, 1'b0, "R7 prbs resume");

        // R8: restart mid-stream
        step(1'b1, 1'b0, "R8 restart");
        step(1'b0, 1'b1, "R8 comma after restart");
        check("R8 comma neg", word_out, 10'h283);
        step(1'b0, 1'b0, "R8 prbs after restart");
        step(1'b1, 1'b0, "R8 restart");
        step(1'b0, 1'b0, "R8 prbs seed");
        check("R8 prbs seed word", word_out, 10'h3FF);
        for (int n = 0; n < 20; n++) step(1'b0, n[1], "R8 continue");

        // R1: synchronous reset mid-run
        rst = 1'b1;
        @(posedge clk);
        #1;
        model(1'b1, 1'b0);
        check("R1 midrun reset word", word_out, 10'h000);
        check("R1 midrun reset valid", {9'd0, word_vld}, 10'h000);
        rst = 1'b0;
        step(1'b0, 1'b1, "R1 after reset comma");
        step(1'b0, 1'b0, "R1 after reset prbs");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule